// File: doc/BRIEF.md
# Dual-Width Host Bus Port for a Character Display Controller

This block is the host-facing port of a character display controller. It watches a register-select line, a read/write line and an enable strobe. It builds complete bytes either from one 8-bit transfer or from a pair of 4-bit transfers on the upper four data lines. Each finished write is handed to an instruction executor as a one-cycle event, tagged as command or data. Reads return one of two things: a status byte (the executor's busy flag and its address counter), or the contents of a read-ahead data register.

The enable strobe is brought into the system clock through a two-flop synchronizer. A transfer is taken on its falling edge.

The port is a single state machine with three states:
- `XFER_FULL`: 8-bit mode.
- `XFER_HIGH`: 4-bit mode, waiting for the high nibble.
- `XFER_LOW`: 4-bit mode, waiting for the low nibble.

Its transitions are:
- FULL→FULL on any strobe.
- HIGH→LOW on the first nibble.
- LOW→HIGH on the second nibble.
- A width override on any completed function-set command. FULL→HIGH or LOW→HIGH when the width bit is 0; LOW→FULL or FULL→FULL when the width bit is 1.

The data register is refilled from RAM only when the executor returns a fetched byte. Fetches are requested after address-set commands and after data reads. As a result, a read that follows any other command returns stale contents.

Top module: `lcd_bus_port`

## Requirements
- R1: The {select, read} pair decodes as follows: 00 is a command write, 01 is a status read, 10 is a data write and 11 is a data read. Each completed write raises `wr_valid` with `wr_is_data` equal to the select line and the assembled byte on `wr_byte`.
- R2: A status read returns the busy input on bit 7 and the 7-bit address counter on bits 6..0.
- R3: After reset the port is in 8-bit mode, no event is pending and `bus_oe` is low.
- R4: A completed command write whose bits 7..5 are 001 is a function-set. Its bit 4 selects the width (1 = 8-bit, 0 = 4-bit) from the next transfer on, and 4-bit mode always restarts at the high nibble.
- R5: In 4-bit mode only data lines 7..4 are taken, high nibble first. No event or fetch request appears until the second nibble completes.
- R6: In 4-bit mode a read drives the high nibble of the read byte on lines 7..4 during the first transfer and the low nibble during the second, with lines 3..0 at zero.
- R7: `bus_oe` is high only while the enable strobe is high with the read line high. Whenever `bus_oe` is low, `bus_dout` is zero.
- R8: `fetch_req` pulses after a command write with bit 7 or bit 6 set (address set) and after every completed data read. A `fetch_valid` cycle loads `fetch_data` into the data register.
- R9: Other commands and data writes request no fetch. A data write loads the written byte into the data register, so a data read without a preceding address set returns that stale byte.
- R10: If `fetch_valid` is high in the same cycle as a data-write event, the written byte wins the data register.
- R11: Each falling strobe edge finishes at most one transfer, and every event is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_e | input | 1 | Host enable strobe (asynchronous) |
| bus_rs | input | 1 | Register select: 0 command/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_din | input | 8 | Host data lines in |
| bus_dout | output | 8 | Host data lines out |
| bus_oe | output | 1 | Output enable for the data lines |
| exec_busy | input | 1 | Busy flag from the executor |
| exec_addr | input | 7 | Address counter from the executor |
| wr_valid | output | 1 | One-cycle write event |
| wr_is_data | output | 1 | Event is a data write (else command) |
| wr_byte | output | 8 | Assembled byte of the event |
| fetch_req | output | 1 | Request for the next RAM byte |
| fetch_valid | input | 1 | Fetched byte is present |
| fetch_data | input | 8 | Fetched RAM byte |

## Verification
Two functions can meet in the data register in the same cycle: a host data write completing, and a late RAM byte returned by the executor. The bench disables its automatic executor model and writes a data byte. It then drives `fetch_valid` with a different byte in exactly the cycle `wr_valid` is high. A following data read must return the written byte and not the fetched one. The nibble sequencer gets the second attention: the bench switches width back and forth and checks that the first 4-bit transfer after every switch is always taken as the high half.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;
    typedef enum logic [1:0] {
        XFER_FULL = 2'd0,
        XFER_HIGH = 2'd1,
        XFER_LOW  = 2'd2
    } xfer_state_t;

    typedef struct packed {
        logic       is_data;
        logic       is_read;
        logic [7:0] byte_val;
    } bus_event_t;
endpackage

// File: rtl/lcd_estrobe_sync.sv
module lcd_estrobe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic strobe_fall
);
    logic [SYNC_STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-1:0], strobe_in};
    end

    assign strobe_fall = chain_q[SYNC_STAGES] & ~chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/lcd_nibble_fsm.sv
module lcd_nibble_fsm
    import lcd_bus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall,
    input  logic              rs,
    input  logic              rw,
    input  logic [DATA_W-1:0] din,
    output xfer_state_t       state,
    output logic              ev_valid,
    output bus_event_t        ev
);
    localparam int NIB = DATA_W / 2;

    xfer_state_t       state_nx;
    logic              done;
    logic [DATA_W-1:0] full_byte;
    logic [NIB-1:0]    hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= XFER_FULL;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        done      = 1'b0;
        full_byte = din;
        unique case (state)
            XFER_FULL: begin
                if (fall) done = 1'b1;
            end
            XFER_HIGH: begin
                if (fall) state_nx = XFER_LOW;
            end
            XFER_LOW: begin
                full_byte = {hi_q, din[DATA_W-1:NIB]};
                if (fall) begin
                    done     = 1'b1;
                    state_nx = XFER_HIGH;
                end
            end
            default: state_nx = XFER_FULL;
        endcase
        if (done && !rs && !rw && full_byte[DATA_W-1:DATA_W-3] == 3'b001)
            state_nx = full_byte[DATA_W-4] ? XFER_FULL : XFER_HIGH;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q     <= '0;
            ev_valid <= 1'b0;
            ev       <= '0;
        end else begin
            if (fall && state == XFER_HIGH) hi_q <= din[DATA_W-1:NIB];
            ev_valid <= done;
            if (done) ev <= '{is_data: rs, is_read: rw, byte_val: full_byte};
        end
    end

    // R5
    half_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && state == XFER_HIGH) |=> !ev_valid);
endmodule

// File: rtl/lcd_read_mux.sv
module lcd_read_mux
    import lcd_bus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  xfer_state_t       state,
    input  logic              oe,
    input  logic              rs,
    input  logic [DATA_W-1:0] data_reg,
    input  logic              busy,
    input  logic [DATA_W-2:0] addr,
    output logic [DATA_W-1:0] dout
);
    localparam int NIB = DATA_W / 2;

    logic [DATA_W-1:0] src;

    always_comb begin
        src  = rs ? data_reg : {busy, addr};
        dout = '0;
        if (oe) begin
            unique case (state)
                XFER_FULL: dout = src;
                XFER_HIGH: dout = {src[DATA_W-1:NIB], {NIB{1'b0}}};
                XFER_LOW:  dout = {src[NIB-1:0], {NIB{1'b0}}};
                default:   dout = '0;
            endcase
        end
    end
endmodule

// File: rtl/lcd_bus_port.sv
module lcd_bus_port
    import lcd_bus_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_e,
    input  logic              bus_rs,
    input  logic              bus_rw,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    input  logic              exec_busy,
    input  logic [DATA_W-2:0] exec_addr,
    output logic              wr_valid,
    output logic              wr_is_data,
    output logic [DATA_W-1:0] wr_byte,
    output logic              fetch_req,
    input  logic              fetch_valid,
    input  logic [DATA_W-1:0] fetch_data
);
    localparam int ADDR_W = DATA_W - 1;

    logic              fall;
    xfer_state_t       state;
    logic              ev_valid;
    bus_event_t        ev;
    logic [DATA_W-1:0] data_reg;
    logic              data_wr_ev;
    logic              addr_set_ev;
    logic              data_rd_ev;

    lcd_estrobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .strobe_in(bus_e), .strobe_fall(fall)
    );

    lcd_nibble_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .fall(fall), .rs(bus_rs), .rw(bus_rw),
        .din(bus_din), .state(state), .ev_valid(ev_valid), .ev(ev)
    );

    assign bus_oe      = bus_e & bus_rw;
    assign wr_valid    = ev_valid & ~ev.is_read;
    assign wr_is_data  = ev.is_data;
    assign wr_byte     = ev.byte_val;
    assign data_wr_ev  = wr_valid & ev.is_data;
    assign data_rd_ev  = ev_valid & ev.is_read & ev.is_data;
    assign addr_set_ev = wr_valid & ~ev.is_data &
                         (ev.byte_val[DATA_W-1] | ev.byte_val[DATA_W-2]);
    assign fetch_req   = data_rd_ev | addr_set_ev;

    always_ff @(posedge clk) begin
        if (!rst_n)           data_reg <= '0;
        else if (data_wr_ev)  data_reg <= ev.byte_val;
        else if (fetch_valid) data_reg <= fetch_data;
    end

    lcd_read_mux #(.DATA_W(DATA_W)) u_mux (
        .state(state), .oe(bus_oe), .rs(bus_rs), .data_reg(data_reg),
        .busy(exec_busy), .addr(exec_addr[ADDR_W-1:0]), .dout(bus_dout)
    );

    // R11
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> !ev_valid);
    // R4
    width_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_is_data && wr_byte[DATA_W-1:DATA_W-3] == 3'b001) |->
        (state == (wr_byte[DATA_W-4] ? XFER_FULL : XFER_HIGH)));
    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_is_data) |=> data_reg == $past(wr_byte));
    // R8
    fetch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !(wr_valid && wr_is_data)) |=> data_reg == $past(fetch_data));
    // R7
    oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_dout == '0);
endmodule

// File: tb/tb_lcd_bus_port.sv
`timescale 1ns/1ps
module tb_lcd_bus_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_e = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
    logic [7:0] bus_din = '0;
    logic [7:0] bus_dout;
    logic       bus_oe;
    logic       exec_busy = 1'b0;
    logic [6:0] exec_addr = '0;
    logic       wr_valid, wr_is_data, fetch_req;
    logic [7:0] wr_byte;
    logic       fetch_valid = 1'b0;
    logic [7:0] fetch_data = '0;

    int checks = 0, failures = 0;
    int wr_cnt = 0, req_cnt = 0;
    logic [7:0] last_byte = '0;
    logic       last_data = 1'b0;
    logic       auto_exec = 1'b1;
    logic       pend = 1'b0;
    logic       finished = 1'b0;
    logic [7:0] q;
    logic       oe_seen;

    always #2 clk = ~clk;

    lcd_bus_port dut (
        .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rs(bus_rs), .bus_rw(bus_rw),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .exec_busy(exec_busy), .exec_addr(exec_addr), .wr_valid(wr_valid),
        .wr_is_data(wr_is_data), .wr_byte(wr_byte), .fetch_req(fetch_req),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data)
    );

    function automatic logic [7:0] ram_at(input logic [6:0] a);
        return {1'b0, a} ^ 8'h5A;
    endfunction

    always @(negedge clk) begin
        if (wr_valid) begin wr_cnt++; last_byte = wr_byte; last_data = wr_is_data; end
        if (fetch_req) req_cnt++;
        if (auto_exec) begin
            fetch_valid = 1'b0;
            if (pend) begin
                fetch_valid = 1'b1;
                fetch_data  = ram_at(exec_addr);
                exec_addr   = exec_addr + 7'd1;
                pend        = 1'b0;
            end
            if (fetch_req) pend = 1'b1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic rs, input logic rw, input logic [7:0] d,
                        output logic [7:0] rd, output logic oe_s);
        @(negedge clk); bus_rs = rs; bus_rw = rw; bus_din = d;
        @(negedge clk); bus_e = 1'b1;
        repeat (3) @(negedge clk);
        rd = bus_dout; oe_s = bus_oe;
        bus_e = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R3 oe idle", bus_oe, 0);
        chk("R7 dout idle", bus_dout, 0);
        chk("R3 no event", wr_cnt, 0);
        exec_addr = 7'h15;
        xfer(0, 1, 8'h00, q, oe_seen);
        chk("R3 8-bit status", q, 8'h15);
        chk("R7 oe on read", oe_seen, 1);
    endtask

    task automatic t_decode();
        int w0, r0;
        w0 = wr_cnt; r0 = req_cnt;
        xfer(0, 0, 8'h0C, q, oe_seen);
        chk("R1 cmd event", wr_cnt, w0 + 1);
        chk("R1 cmd tag", {last_data, last_byte}, {1'b0, 8'h0C});
        chk("R7 oe low on write", oe_seen, 0);
        chk("R9 no fetch on cmd", req_cnt, r0);
        xfer(1, 0, 8'h41, q, oe_seen);
        chk("R1 data tag", {last_data, last_byte}, {1'b1, 8'h41});
        chk("R9 no fetch on data write", req_cnt, r0);
    endtask

    task automatic t_status();
        exec_busy = 1'b1; exec_addr = 7'h2B;
        xfer(0, 1, 8'h00, q, oe_seen);
        chk("R2 busy status", q, 8'hAB);
        exec_busy = 1'b0;
    endtask

    task automatic t_prefetch();
        int r0;
        r0 = req_cnt;
        exec_addr = 7'h10;
        xfer(0, 0, 8'h90, q, oe_seen);
        chk("R8 fetch after addr set", req_cnt, r0 + 1);
        xfer(1, 1, 8'h00, q, oe_seen);
        chk("R8 first read", q, ram_at(7'h10));
        xfer(1, 1, 8'h00, q, oe_seen);
        chk("R8 second read", q, ram_at(7'h11));
    endtask

    task automatic t_stale();
        xfer(1, 0, 8'h37, q, oe_seen);
        xfer(0, 0, 8'h0C, q, oe_seen);
        xfer(1, 1, 8'h00, q, oe_seen);
        chk("R9 stale read", q, 8'h37);
    endtask

    task automatic t_coincide();
        auto_exec = 1'b0; pend = 1'b0; fetch_valid = 1'b0;
        @(negedge clk); bus_rs = 1'b1; bus_rw = 1'b0; bus_din = 8'h6E;
        @(negedge clk); bus_e = 1'b1;
        repeat (3) @(negedge clk);
        bus_e = 1'b0;
        repeat (3) @(negedge clk);
        fetch_valid = 1'b1; fetch_data = 8'h99;
        chk("R10 event in overlap cycle", wr_valid, 1);
        @(negedge clk); fetch_valid = 1'b0;
        repeat (4) @(negedge clk);
        xfer(1, 1, 8'h00, q, oe_seen);
        chk("R10 write wins", q, 8'h6E);
        auto_exec = 1'b1;
    endtask

    task automatic t_nibble();
        int w0, r0;
        xfer(0, 0, 8'h20, q, oe_seen);
        w0 = wr_cnt; r0 = req_cnt;
        xfer(1, 0, 8'h50, q, oe_seen);
        chk("R5 no event after first nibble", wr_cnt, w0);
        xfer(1, 0, 8'hCF, q, oe_seen);
        chk("R5 assembled byte", {last_data, last_byte}, {1'b1, 8'h5C});
        exec_busy = 1'b1; exec_addr = 7'h6A;
        xfer(0, 1, 8'h00, q, oe_seen);
        chk("R6 status high nibble", q, 8'hE0);
        xfer(0, 1, 8'h00, q, oe_seen);
        chk("R6 status low nibble", q, 8'hA0);
        exec_busy = 1'b0;
        exec_addr = 7'h20;
        xfer(0, 0, 8'hA0, q, oe_seen);
        chk("R5 no fetch after half addr", req_cnt, r0);
        xfer(0, 0, 8'h00, q, oe_seen);
        chk("R8 fetch after 4-bit addr", req_cnt, r0 + 1);
        xfer(1, 1, 8'h00, q, oe_seen);
        chk("R6 data high nibble", q, 8'h70);
        xfer(1, 1, 8'h00, q, oe_seen);
        chk("R6 data low nibble", q, 8'hA0);
    endtask

    task automatic t_width_swap();
        xfer(0, 0, 8'h30, q, oe_seen);
        xfer(0, 0, 8'h00, q, oe_seen);
        xfer(0, 0, 8'h06, q, oe_seen);
        chk("R4 back to 8-bit", last_byte, 8'h06);
        xfer(0, 0, 8'h20, q, oe_seen);
        xfer(0, 0, 8'h30, q, oe_seen);
        xfer(0, 0, 8'h8F, q, oe_seen);
        chk("R4 restart at high nibble", last_byte, 8'h38);
        chk("R11 one event per byte", wr_valid, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_decode();
        t_status();
        t_prefetch();
        t_stale();
        t_coincide();
        t_nibble();
        t_width_swap();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule